// File: doc/BRIEF.md
# Message-Interrupt Vector Mask and Pending Controller

This block holds the vector table and the pending array for a set of message-signalled interrupt vectors. Software writes 32-bit words into a table window. Each 16-byte entry holds a 64-bit message address, a 32-bit message payload and a control word, and bit 0 of the control word masks the vector. A separate function-wide mask bit masks every vector together. A vector counts as masked when either of the two masks is set.

Interrupt sources raise per-vector request pulses. A request on a masked vector is parked in the pending array. A request on an unmasked vector becomes a message at once. The block acts only when a vector's effective mask actually changes. When a vector goes from masked to unmasked with its pending bit set, the bit is cleared and exactly one message is queued for that vector.

A change of the function mask starts a serial scan, one vector per clock. The scan compares each vector's state under the old function mask with its state under the new one. While the scan runs, `busy` is high and all table and function-mask writes are dropped.

Messages leave on a valid/ready stream that carries the vector index with its address and payload. The payload is held stable while `msg_valid` is high and `msg_ready` is low. When several vectors are waiting, the lowest index goes first.

Top module: `msix_mask_ctrl`

## Requirements
- R1: After reset every vector's own mask bit is set, the function mask is clear, every pending bit is clear, `msg_valid` is low and `busy` is low.
- R2: `vec_masked[v]` is high exactly when the function mask is set or vector v's mask bit is set. The mask bit is bit 0 of the control word at byte offset 12 of the entry. Writes to the other three words of an entry do not change the mask.
- R3: A request on an effectively masked vector sets that vector's pending bit and sends no message.
- R4: A request on an unmasked vector sends one message for that vector and leaves its pending bit clear.
- R5: A table write that takes a vector from masked to unmasked while its pending bit is set clears the bit and sends exactly one message for that vector. A write that leaves the effective state unchanged leaves the pending bit unchanged and sends nothing.
- R6: A function-mask write with a new value raises `busy` for exactly NUM_VEC cycles. During that time every vector is checked against the old function mask and the R5 rule is applied. A write of the current value raises no `busy`.
- R7: While `busy` is high, table writes and function-mask writes are ignored.
- R8: Only the low TBL_AW bits of the table address are used, and the two lowest of those are dropped. The vector index is that byte offset divided by 16. Offset bits [3:2] select the word: 0 is address low, 1 is address high, 2 is payload, 3 is control.
- R9: A table write whose vector index is NUM_VEC or higher changes no state and sends nothing.
- R10: `pend_bits` holds bit (v mod 8) of byte (v div 8) for vector v, so bit v of the vector is vector v's pending bit. Bits at index NUM_VEC and above read 0.
- R11: `msg_vec`, `msg_addr` and `msg_data` stay stable while `msg_valid` is high and `msg_ready` is low. `msg_addr` and `msg_data` carry the entry's {address high, address low} and payload. Waiting vectors are sent in ascending index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Table word write strobe |
| tbl_wr_addr | input | ADDR_W | Byte address of the table write |
| tbl_wr_data | input | 32 | Table write data |
| fmask_wr_en | input | 1 | Function-mask write strobe |
| fmask_wr_val | input | 1 | New function-mask value |
| busy | output | 1 | Scan in progress; writes are dropped |
| irq_req | input | NUM_VEC | Per-vector interrupt request pulses |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | Consumer accepts the offered message |
| msg_vec | output | VW | Vector index of the message |
| msg_addr | output | 64 | Message address from the entry |
| msg_data | output | 32 | Message payload from the entry |
| pend_bits | output | PBA_BITS | Packed pending array |
| vec_masked | output | NUM_VEC | Effective mask per vector |

## Verification
The assertions check, on every cycle, the properties that hold locally:
- pending bits follow the masked-request and unmask rules;
- writes to non-control words leave the mask alone;
- a stalled message keeps its payload;
- waiting requests reach the output within a cycle;
- the function mask is frozen during a scan.

Only the bench scenarios can show the rest:
- that exactly one message leaves per unmask event;
- the ascending service order;
- the exact scan length;
- the address aliasing and the ignoring of out-of-range entries.

To cover these, the bench sweeps every combination of function mask, old and new vector mask, pending state and written word for each vector. It also runs all 64 vector-mask patterns through a function-mask release.

// File: rtl/msix_mc_pkg.sv
package msix_mc_pkg;
  localparam int ENTRY_SHIFT   = 4;
  localparam int CTRL_MASK_BIT = 0;

  typedef enum logic [1:0] {
    DW_ADDR_LO = 2'd0,
    DW_ADDR_HI = 2'd1,
    DW_DATA    = 2'd2,
    DW_CTRL    = 2'd3
  } dw_sel_e;
endpackage

// File: rtl/msix_mc_slot.sv
module msix_mc_slot
  import msix_mc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  dw_sel_e     wr_dw,
  input  logic [31:0] wr_data,
  input  logic        fmask,
  input  logic        scan_hit,
  input  logic        scan_old_fmask,
  input  logic        irq,
  output logic        eff_masked,
  output logic        pend,
  output logic        fire,
  output logic [63:0] msg_addr,
  output logic [31:0] msg_data
);
  logic        vmask_q, pend_q;
  logic [31:0] lo_q, hi_q, dat_q;
  logic        vmask_nx, was_m, now_m, unmask_wr, unmask_scan, unmask_ev;

  always_comb begin
    vmask_nx = vmask_q;
    if (wr_en && wr_dw == DW_CTRL) vmask_nx = wr_data[CTRL_MASK_BIT];
    was_m       = fmask | vmask_q;
    now_m       = fmask | vmask_nx;
    // a write acts only on a real masked -> unmasked change
    unmask_wr   = wr_en && was_m && !now_m;
    // scan: old state under the previous function mask versus the current state
    unmask_scan = scan_hit && (scan_old_fmask | vmask_q) && !was_m;
    unmask_ev   = unmask_wr | unmask_scan;
    fire        = (irq && !was_m) || (unmask_ev && (pend_q || irq));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vmask_q <= 1'b1;
      pend_q  <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
      dat_q   <= '0;
    end else begin
      vmask_q <= vmask_nx;
      pend_q  <= unmask_ev ? 1'b0 : (pend_q | (irq & was_m));
      if (wr_en) begin
        case (wr_dw)
          DW_ADDR_LO: lo_q  <= wr_data;
          DW_ADDR_HI: hi_q  <= wr_data;
          DW_DATA:    dat_q <= wr_data;
          default:    ;
        endcase
      end
    end
  end

  assign eff_masked = was_m;
  assign pend       = pend_q;
  assign msg_addr   = {hi_q, lo_q};
  assign msg_data   = dat_q;

  a_r3_masked_req_pends: assert property (@(posedge clk) disable iff (!rst_n)
    irq && was_m && !unmask_ev |=> pend_q);
  a_r4_open_req_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !was_m && !pend_q |=> !pend_q);
  a_r5_unmask_clears: assert property (@(posedge clk) disable iff (!rst_n)
    unmask_ev |=> !pend_q);
  a_r2_other_word_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_dw != DW_CTRL |=> $stable(vmask_q));
endmodule

// File: rtl/msix_mc_arb.sv
module msix_mc_arb #(
  parameter int NUM_VEC = 8,
  parameter int VW      = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_VEC-1:0]       fire,
  input  logic [NUM_VEC-1:0][63:0] addr_all,
  input  logic [NUM_VEC-1:0][31:0] data_all,
  input  logic                     msg_ready,
  output logic                     msg_valid,
  output logic [VW-1:0]            msg_vec,
  output logic [63:0]              msg_addr,
  output logic [31:0]              msg_data
);
  logic [NUM_VEC-1:0] req_q, req_nx, clr_mask;
  logic [VW-1:0]      pick_idx;
  logic               pick_any, load, take;
  logic               vld_q;
  logic [VW-1:0]      vec_q;
  logic [63:0]        addr_q;
  logic [31:0]        data_q;

  always_comb begin
    pick_any = |req_q;
    pick_idx = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (req_q[i]) pick_idx = VW'(i);
    end
    load     = !vld_q || msg_ready;
    take     = load && pick_any;
    clr_mask = take ? (NUM_VEC'(1) << pick_idx) : '0;
    req_nx   = (req_q & ~clr_mask) | fire;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      vld_q  <= 1'b0;
      vec_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      req_q <= req_nx;
      if (load) begin
        vld_q <= pick_any;
        if (pick_any) begin
          vec_q  <= pick_idx;
          addr_q <= addr_all[pick_idx];
          data_q <= data_all[pick_idx];
        end
      end
    end
  end

  assign msg_valid = vld_q;
  assign msg_vec   = vec_q;
  assign msg_addr  = addr_q;
  assign msg_data  = data_q;

  a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vec) && $stable(msg_addr) && $stable(msg_data));
  a_r11_waiting_reaches_out: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q && (|req_q) |=> vld_q);
endmodule

// File: rtl/msix_mask_ctrl.sv
module msix_mask_ctrl
  import msix_mc_pkg::*;
#(
  parameter  int NUM_VEC  = 8,
  parameter  int TBL_AW   = 12,
  parameter  int ADDR_W   = 32,
  localparam int VW       = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int PBA_BITS = ((NUM_VEC + 7) / 8) * 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tbl_wr_en,
  input  logic [ADDR_W-1:0]   tbl_wr_addr,
  input  logic [31:0]         tbl_wr_data,
  input  logic                fmask_wr_en,
  input  logic                fmask_wr_val,
  output logic                busy,
  input  logic [NUM_VEC-1:0]  irq_req,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [VW-1:0]       msg_vec,
  output logic [63:0]         msg_addr,
  output logic [31:0]         msg_data,
  output logic [PBA_BITS-1:0] pend_bits,
  output logic [NUM_VEC-1:0]  vec_masked
);
  localparam int IDX_W = TBL_AW - ENTRY_SHIFT;

  logic [IDX_W-1:0] wr_idx;
  dw_sel_e          wr_dw;
  logic             wr_in_range, wr_acc, fm_acc;
  logic             unused_addr;

  // window offset: upper address bits and byte lanes play no part
  assign wr_idx      = tbl_wr_addr[TBL_AW-1:ENTRY_SHIFT];
  assign wr_dw       = dw_sel_e'(tbl_wr_addr[3:2]);
  assign unused_addr = ^{tbl_wr_addr[ADDR_W-1:TBL_AW], tbl_wr_addr[1:0]};

  logic          scan_busy_q, fmask_q, old_fmask_q;
  logic [VW-1:0] scan_idx_q;

  assign wr_in_range = ({1'b0, wr_idx} < (IDX_W + 1)'(NUM_VEC));
  assign wr_acc      = tbl_wr_en && !scan_busy_q && wr_in_range;
  assign fm_acc      = fmask_wr_en && !scan_busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_busy_q <= 1'b0;
      scan_idx_q  <= '0;
      fmask_q     <= 1'b0;
      old_fmask_q <= 1'b0;
    end else if (fm_acc) begin
      fmask_q <= fmask_wr_val;
      if (fmask_wr_val != fmask_q) begin
        scan_busy_q <= 1'b1;
        scan_idx_q  <= '0;
        old_fmask_q <= fmask_q;
      end
    end else if (scan_busy_q) begin
      if (scan_idx_q == VW'(NUM_VEC - 1)) scan_busy_q <= 1'b0;
      else                                scan_idx_q  <= scan_idx_q + 1'b1;
    end
  end

  logic [NUM_VEC-1:0]       pend_vec, fire_vec;
  logic [NUM_VEC-1:0][63:0] addr_all;
  logic [NUM_VEC-1:0][31:0] data_all;

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_slot
    msix_mc_slot u_slot (
      .clk            (clk),
      .rst_n          (rst_n),
      .wr_en          (wr_acc && (wr_idx == IDX_W'(g))),
      .wr_dw          (wr_dw),
      .wr_data        (tbl_wr_data),
      .fmask          (fmask_q),
      .scan_hit       (scan_busy_q && (scan_idx_q == VW'(g))),
      .scan_old_fmask (old_fmask_q),
      .irq            (irq_req[g]),
      .eff_masked     (vec_masked[g]),
      .pend           (pend_vec[g]),
      .fire           (fire_vec[g]),
      .msg_addr       (addr_all[g]),
      .msg_data       (data_all[g])
    );
  end

  msix_mc_arb #(.NUM_VEC(NUM_VEC), .VW(VW)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire_vec),
    .addr_all  (addr_all),
    .data_all  (data_all),
    .msg_ready (msg_ready),
    .msg_valid (msg_valid),
    .msg_vec   (msg_vec),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data)
  );

  // vector v lands in byte v/8 at bit v%8, which is flat bit v
  always_comb begin
    pend_bits                = '0;
    pend_bits[NUM_VEC-1:0]   = pend_vec;
  end

  assign busy = scan_busy_q;

  a_r7_fmask_frozen_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
    scan_busy_q |=> fmask_q == $past(fmask_q));
  a_r6_scan_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_busy_q) |-> $past(fmask_wr_en) && (fmask_q != old_fmask_q));
  a_r9_far_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr_en && !scan_busy_q && !wr_in_range && !fmask_wr_en |=> $stable(vec_masked));
endmodule

// File: tb/msix_mask_ctrl_test.sv
module msix_mask_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  localparam int TAW = 8;
  localparam int AW = 16;
  localparam int VW = 3;
  localparam int PB = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tbl_wr_en = 1'b0, fmask_wr_en = 1'b0, fmask_wr_val = 1'b0, msg_ready = 1'b0;
  logic [AW-1:0] tbl_wr_addr = '0;
  logic [31:0] tbl_wr_data = '0;
  logic [NV-1:0] irq_req = '0;
  logic busy, msg_valid;
  logic [VW-1:0] msg_vec;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;
  logic [PB-1:0] pend_bits;
  logic [NV-1:0] vec_masked;

  msix_mask_ctrl #(.NUM_VEC(NV), .TBL_AW(TAW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr),
    .tbl_wr_data(tbl_wr_data), .fmask_wr_en(fmask_wr_en), .fmask_wr_val(fmask_wr_val),
    .busy(busy), .irq_req(irq_req), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vec(msg_vec), .msg_addr(msg_addr), .msg_data(msg_data),
    .pend_bits(pend_bits), .vec_masked(vec_masked));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0, bad = 0;
  bit m_vmask[NV];
  bit m_pend[NV];
  bit m_fmask;
  int m_cnt[NV];
  logic [31:0] m_lo[NV], m_hi[NV], m_dat[NV];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit eff(input int v);
    return m_fmask | m_vmask[v];
  endfunction

  function automatic logic [AW-1:0] adr(input int v, input int dw);
    return AW'(v * 16 + dw * 4);
  endfunction

  task automatic check_state(input string req);
    logic [PB-1:0] ep = '0;
    logic [NV-1:0] em;
    for (int v = 0; v < NV; v++) begin
      ep[(v / 8) * 8 + (v % 8)] = m_pend[v];
      em[v] = eff(v);
    end
    chk(pend_bits == ep, {"R10 pending array, ", req}, 64'(pend_bits), 64'(ep));
    chk(vec_masked == em, {"R2 effective mask, ", req}, 64'(vec_masked), 64'(em));
  endtask

  task automatic m_tbl(input logic [AW-1:0] a, input logic [31:0] d);
    int v = int'(a[7:4]);
    int dw = int'(a[3:2]);
    bit was, now;
    if (v >= NV) return;
    was = eff(v);
    case (dw)
      0: m_lo[v] = d;
      1: m_hi[v] = d;
      2: m_dat[v] = d;
      default: m_vmask[v] = d[0];
    endcase
    now = eff(v);
    if (was && !now && m_pend[v]) begin
      m_pend[v] = 1'b0;
      m_cnt[v]++;
    end
  endtask

  task automatic m_fm(input bit val);
    for (int v = 0; v < NV; v++) begin
      if ((m_fmask | m_vmask[v]) && !(val | m_vmask[v]) && m_pend[v]) begin
        m_pend[v] = 1'b0;
        m_cnt[v]++;
      end
    end
    m_fmask = val;
  endtask

  task automatic tbl_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_addr = a; tbl_wr_data = d;
    @(negedge clk);
    tbl_wr_en = 1'b0;
    m_tbl(a, d);
  endtask

  task automatic fm_wr(input bit val);
    int n = 0;
    bit changed = (val != m_fmask);
    @(negedge clk);
    fmask_wr_en = 1'b1; fmask_wr_val = val;
    @(negedge clk);
    fmask_wr_en = 1'b0;
    m_fm(val);
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk(n == (changed ? NV : 0), "R6 scan length", 64'(n), 64'(changed ? NV : 0));
  endtask

  task automatic irq(input logic [NV-1:0] bits);
    @(negedge clk);
    irq_req = bits;
    @(negedge clk);
    irq_req = '0;
    for (int v = 0; v < NV; v++) begin
      if (bits[v]) begin
        if (eff(v)) m_pend[v] = 1'b1;
        else m_cnt[v]++;
      end
    end
  endtask

  task automatic drain(input string req);
    int idle = 0, guard = 0, left = 0;
    int v;
    while (idle < 4 && guard < 64) begin
      guard++;
      if (msg_valid) begin
        v = int'(msg_vec);
        chk(v < NV && m_cnt[v] > 0, {"R5 message count, ", req}, 64'(v), 64'(0));
        if (v < NV) begin
          chk(msg_addr == {m_hi[v], m_lo[v]}, {"R11 message address, ", req}, msg_addr, {m_hi[v], m_lo[v]});
          chk(msg_data == m_dat[v], {"R11 message payload, ", req}, 64'(msg_data), 64'(m_dat[v]));
          if (m_cnt[v] > 0) m_cnt[v]--;
        end
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
        idle = 0;
      end else begin
        idle++;
        @(negedge clk);
      end
    end
    for (int k = 0; k < NV; k++) left += m_cnt[k];
    chk(left == 0, {"R5 missing messages, ", req}, 64'(left), 64'(0));
    for (int k = 0; k < NV; k++) m_cnt[k] = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int v = 0; v < NV; v++) begin
      m_vmask[v] = 1'b1; m_pend[v] = 1'b0; m_cnt[v] = 0;
      m_lo[v] = '0; m_hi[v] = '0; m_dat[v] = '0;
    end
    m_fmask = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check_state("R1 reset");
    chk(msg_valid == 1'b0, "R1 msg_valid after reset", 64'(msg_valid), 64'(0));
    chk(busy == 1'b0, "R1 busy after reset", 64'(busy), 64'(0));

    // R8: fill entries through aliased addresses (upper bits and byte lanes set)
    for (int v = 0; v < NV; v++) begin
      tbl_wr(adr(v, 0) | 16'h5A00 | 16'h1, 32'hF000_0000 + 32'(v * 16));
      tbl_wr(adr(v, 1) | 16'hA300 | 16'h2, 32'h0000_0100 + 32'(v));
      tbl_wr(adr(v, 2) | 16'h0100 | 16'h3, 32'h0000_0D00 + 32'(v));
      tbl_wr(adr(v, 3) | 16'hC300 | 16'h1, 32'hFFFF_FFFE);
    end
    check_state("R8 aliased control writes");
    for (int v = 0; v < NV; v++) tbl_wr(adr(v, 3), 32'h1);
    check_state("R8 masks restored");
    drain("R8");

    // R9: entries at or above NUM_VEC inside the window
    for (int v = NV; v < 16; v++) begin
      for (int dw = 0; dw < 4; dw++) tbl_wr(adr(v, dw), 32'h0);
    end
    check_state("R9 out-of-range writes");
    drain("R9");

    // R2 R3 R4 R5: every mask, pending and written-word combination per vector
    for (int v = 0; v < NV; v++)
      for (int fm = 0; fm < 2; fm++)
        for (int vb = 0; vb < 2; vb++)
          for (int pb = 0; pb < 2; pb++)
            for (int nb = 0; nb < 2; nb++)
              for (int kind = 0; kind < 2; kind++) begin
                fm_wr(1'b1);
                tbl_wr(adr(v, 3), 32'h1);
                drain("R5 setup");
                if (pb != 0) irq(NV'(1) << v);
                tbl_wr(adr(v, 3), 32'(vb));
                fm_wr(fm[0]);
                drain("R6 setup");
                check_state("R3 setup");
                if (kind != 0) tbl_wr(adr(v, 3), 32'(nb));
                else tbl_wr(adr(v, 2), (m_dat[v] & 32'hFFFF_FFFE) | 32'(nb));
                check_state("R5 after write");
                drain("R5 after write");
                irq(NV'(1) << v);
                check_state("R3 R4 after request");
                drain("R4 after request");
              end

    // R6: all vector-mask patterns through a function-mask release
    for (int pat = 0; pat < 64; pat++) begin
      fm_wr(1'b1);
      for (int v = 0; v < NV; v++) tbl_wr(adr(v, 3), 32'(pat[v]));
      irq(NV'((pat * 5 + 3) & 63));
      check_state("R6 before release");
      fm_wr(1'b0);
      check_state("R6 after scan");
      drain("R6 scan messages");
    end

    // R7: writes during the scan are dropped
    fm_wr(1'b1);
    tbl_wr(adr(2, 3), 32'h0);
    tbl_wr(adr(3, 3), 32'h1);
    drain("R7 setup");
    irq(NV'(1) << 2);
    @(negedge clk);
    fmask_wr_en = 1'b1; fmask_wr_val = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R6 busy after change", 64'(busy), 64'(1));
    tbl_wr_en = 1'b1; tbl_wr_addr = adr(3, 3); tbl_wr_data = 32'h0;
    fmask_wr_val = 1'b1;
    @(negedge clk);
    tbl_wr_en = 1'b0; fmask_wr_en = 1'b0;
    m_fm(1'b0);
    for (int n = 0; n < 20 && busy; n++) @(negedge clk);
    check_state("R7 writes while busy");
    drain("R7");

    // R11: simultaneous requests, held payload, ascending order
    for (int v = 0; v < NV; v++) tbl_wr(adr(v, 3), 32'h0);
    drain("R11 setup");
    @(negedge clk);
    irq_req = 6'b101101;
    @(negedge clk);
    irq_req = '0;
    @(negedge clk);
    for (int h = 0; h < 3; h++) begin
      chk(msg_valid && msg_vec == 3'd0, "R11 held while stalled", 64'(msg_vec), 64'(0));
      chk(msg_addr == {m_hi[0], m_lo[0]}, "R11 held address", msg_addr, {m_hi[0], m_lo[0]});
      @(negedge clk);
    end
    for (int k = 0; k < NV; k++) begin
      if (k == 0 || k == 2 || k == 3 || k == 5) begin
        chk(msg_valid && int'(msg_vec) == k, "R11 ascending order", 64'(msg_vec), 64'(k));
        chk(msg_data == m_dat[k], "R11 ordered payload", 64'(msg_data), 64'(m_dat[k]));
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
      end
    end
    repeat (2) @(negedge clk);
    chk(msg_valid == 1'b0, "R4 one message per request", 64'(msg_valid), 64'(0));
    check_state("R4 pending untouched");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule